// File: doc/BRIEF.md
# Ordered Dial Combination Lock

This block is a clocked controller for a dial lock that opens only when three dial operations arrive in one fixed order. Each operation names a turning direction (right or left) and the number the dial stopped on, and is presented as a single-cycle strobe. The right numbers in the wrong order do not open the lock. Progress through the combination is kept as named partial-progress states.

A comparator stage checks each incoming operation against the three required steps. A small state machine then uses those match strobes to advance, to fall back, or to open. By default the combination is right to 13, then left to 22, then right to 3. The steps are parameters fixed at elaboration. Once open, the lock stays open and ignores the dial until a relock pulse closes it again.

Top module: `comboLock`

## Requirements
- R1: A synchronous active-high reset puts the machine in idle (`lockState` = 00) with `unlocked` low, one clock edge after `rst` is sampled high.
- R2: The state code on `lockState` is idle = 00, first step done = 01, first two steps done = 10, open = 11. `unlocked` is high only while the code is 11.
- R3: Without `opValid`, the state does not change, whatever `opDir` and `opValue` carry.
- R4: The direction encoding is `opDir` 0 = right, 1 = left. With default parameters, right 13 moves idle to 01, left 22 moves 01 to 10, and right 3 moves 10 to 11. The new state shows after the clock edge at which the strobe is sampled.
- R5: In a closed state, an operation that is not the expected next step returns the machine to idle. The exception is an operation equal to the first step (right 13), which moves it to 01.
- R6: In the open state, every dial operation, of any direction and value, leaves the lock open.
- R7: `relock` forces idle from any state at the next edge. It takes priority over a dial strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opValid | input | 1 | One-cycle strobe marking a completed dial operation |
| opDir | input | 1 | Turning direction of the operation, 0 = right, 1 = left |
| opValue | input | VAL_W (5) | Dial number the operation stopped on |
| relock | input | 1 | Closes the lock and returns to idle |
| unlocked | output | 1 | High while the lock is open |
| lockState | output | 2 | Current state code |

## Verification
The hardest situations to reach from the ports are the fall-back cases deep in the sequence. Two examples: a repeated first step while the machine waits for the third step, and a wrong direction paired with a correct number. Both need the machine to be driven through a valid prefix first. The bench resets and then replays the correct prefix for each of the four states. From each state it applies every one of the 64 direction and value pairs, so each fall-back, restart and ignore path is hit once, and it compares each result against an arithmetic model of the step rules.

// File: rtl/comboLockPkg.sv
package comboLockPkg;

  typedef enum logic [1:0] {
    LK_IDLE   = 2'b00,
    LK_FIRST  = 2'b01,
    LK_SECOND = 2'b10,
    LK_OPEN   = 2'b11
  } lockState_e;

  // Strobes passed from the comparator datapath to the control FSM
  typedef struct packed {
    logic strobe;
    logic hitStep0;
    logic hitStep1;
    logic hitStep2;
  } stepHits_t;

endpackage

// File: rtl/comboLockMatch.sv
module comboLockMatch
  import comboLockPkg::*;
#(
  parameter int VAL_W = 5,
  parameter bit S0_DIR = 1'b0,
  parameter int S0_VAL = 13,
  parameter bit S1_DIR = 1'b1,
  parameter int S1_VAL = 22,
  parameter bit S2_DIR = 1'b0,
  parameter int S2_VAL = 3
) (
  input  logic             opValid,
  input  logic             opDir,
  input  logic [VAL_W-1:0] opValue,
  output stepHits_t        hits
);
  localparam int NSTEPS = 3;
  localparam logic [NSTEPS-1:0] EXP_DIR = {S2_DIR, S1_DIR, S0_DIR};
  localparam logic [NSTEPS-1:0][VAL_W-1:0] EXP_VAL =
    {VAL_W'(S2_VAL), VAL_W'(S1_VAL), VAL_W'(S0_VAL)};

  logic [NSTEPS-1:0] hitVec;

  for (genvar k = 0; k < NSTEPS; k++) begin : g_cmp
    assign hitVec[k] = opValid && (opDir == EXP_DIR[k]) && (opValue == EXP_VAL[k]);
  end

  assign hits.strobe   = opValid;
  assign hits.hitStep0 = hitVec[0];
  assign hits.hitStep1 = hitVec[1];
  assign hits.hitStep2 = hitVec[2];
endmodule

// File: rtl/comboLockCtrl.sv
module comboLockCtrl
  import comboLockPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       relock,
  input  stepHits_t  hits,
  output lockState_e curState
);
  lockState_e nextState;
  lockState_e fallBack;

  // a failed step restarts at FIRST if it is itself the opening step
  assign fallBack = hits.hitStep0 ? LK_FIRST : LK_IDLE;

  always_comb begin
    nextState = curState;
    if (relock) begin
      nextState = LK_IDLE;
    end else if (hits.strobe) begin
      unique case (curState)
        LK_IDLE:   nextState = fallBack;
        LK_FIRST:  nextState = hits.hitStep1 ? LK_SECOND : fallBack;
        LK_SECOND: nextState = hits.hitStep2 ? LK_OPEN : fallBack;
        LK_OPEN:   nextState = LK_OPEN;
        default:   nextState = LK_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) curState <= LK_IDLE;
    else     curState <= nextState;
  end
endmodule

// File: rtl/comboLock.sv
module comboLock
  import comboLockPkg::*;
#(
  parameter int VAL_W = 5,
  parameter bit S0_DIR = 1'b0,
  parameter int S0_VAL = 13,
  parameter bit S1_DIR = 1'b1,
  parameter int S1_VAL = 22,
  parameter bit S2_DIR = 1'b0,
  parameter int S2_VAL = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             opValid,
  input  logic             opDir,
  input  logic [VAL_W-1:0] opValue,
  input  logic             relock,
  output logic             unlocked,
  output logic [1:0]       lockState
);
  stepHits_t  hits;
  lockState_e curState;

  comboLockMatch #(
    .VAL_W(VAL_W), .S0_DIR(S0_DIR), .S0_VAL(S0_VAL),
    .S1_DIR(S1_DIR), .S1_VAL(S1_VAL), .S2_DIR(S2_DIR), .S2_VAL(S2_VAL)
  ) i_match (
    .opValid(opValid), .opDir(opDir), .opValue(opValue), .hits(hits)
  );

  comboLockCtrl i_ctrl (
    .clk(clk), .rst(rst), .relock(relock), .hits(hits), .curState(curState)
  );

  assign lockState = curState;
  assign unlocked  = (curState == LK_OPEN);
endmodule

// File: rtl/comboLockChecker.sv
module comboLockChecker #(
  parameter int VAL_W = 5,
  parameter bit S0_DIR = 1'b0,
  parameter int S0_VAL = 13
) (
  input logic             clk,
  input logic             rst,
  input logic             opValid,
  input logic             opDir,
  input logic [VAL_W-1:0] opValue,
  input logic             relock,
  input logic             unlocked,
  input logic [1:0]       lockState
);
  // R1: reset lands in idle, closed
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (lockState == 2'b00 && !unlocked));

  // R3: no strobe, no movement
  a_r3_hold_idle_input: assert property (@(posedge clk) disable iff (rst)
    (!opValid && !relock) |=> $stable(lockState));

  // R4: the first step from idle reaches 01
  a_r4_first_step: assert property (@(posedge clk) disable iff (rst)
    (lockState == 2'b00 && opValid && !relock && opDir == S0_DIR
     && opValue == VAL_W'(S0_VAL)) |=> lockState == 2'b01);

  // R4: opening only ever follows the two-steps-done state
  a_r4_open_from_second: assert property (@(posedge clk) disable iff (rst)
    $rose(unlocked) |-> $past(lockState) == 2'b10);

  // R6: open stays open until relock
  a_r6_open_sticky: assert property (@(posedge clk) disable iff (rst)
    (lockState == 2'b11 && !relock) |=> lockState == 2'b11);

  // R7: relock wins over everything
  a_r7_relock_idle: assert property (@(posedge clk) disable iff (rst)
    relock |=> (lockState == 2'b00 && !unlocked));
endmodule

bind comboLock comboLockChecker #(
  .VAL_W(VAL_W), .S0_DIR(S0_DIR), .S0_VAL(S0_VAL)
) i_comboLockChecker (
  .clk(clk), .rst(rst), .opValid(opValid), .opDir(opDir), .opValue(opValue),
  .relock(relock), .unlocked(unlocked), .lockState(lockState)
);

// File: tb/test_comboLock.sv
`timescale 1ns/1ps
module test_comboLock;
  localparam int VAL_W = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic opValid = 1'b0;
  logic opDir = 1'b0;
  logic [VAL_W-1:0] opValue = '0;
  logic relock = 1'b0;
  logic unlocked;
  logic [1:0] lockState;

  int vectors = 0;
  int miscompares = 0;

  always #2.5 clk = ~clk;

  comboLock i_comboLock (
    .clk(clk), .rst(rst), .opValid(opValid), .opDir(opDir), .opValue(opValue),
    .relock(relock), .unlocked(unlocked), .lockState(lockState)
  );

  // step k of the combination, computed from the requirement text
  function automatic bit stepDir(int k);
    return (k == 1);
  endfunction
  function automatic int stepVal(int k);
    return (k == 0) ? 13 : (k == 1) ? 22 : 3;
  endfunction

  function automatic logic [1:0] model(logic [1:0] s, bit d, int v);
    bit isFirst = (d == stepDir(0)) && (v == stepVal(0));
    if (s == 2'd3) return 2'd3;
    if (d == stepDir(s) && v == stepVal(s)) return s + 2'd1;
    return isFirst ? 2'd1 : 2'd0;
  endfunction

  task automatic check(string req, logic [1:0] expState);
    vectors++;
    if (lockState !== expState || unlocked !== (expState == 2'd3)) begin
      miscompares++;
      $display("FAIL %s: state=%b unlocked=%b expected state=%b unlocked=%b",
               req, lockState, unlocked, expState, (expState == 2'd3));
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; opValid = 1'b0; relock = 1'b0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic applyOp(bit d, int v, bit rl);
    opValid = 1'b1; opDir = d; opValue = VAL_W'(v); relock = rl;
    @(negedge clk);
    opValid = 1'b0; relock = 1'b0;
  endtask

  task automatic reach(int s);
    doReset();
    for (int k = 0; k < s; k++) applyOp(stepDir(k), stepVal(k), 1'b0);
  endtask

  initial begin
    // R1: reset state
    doReset();
    check("R1", 2'd0);

    // R2/R4: correct walk through every state code
    for (int k = 0; k < 3; k++) begin
      applyOp(stepDir(k), stepVal(k), 1'b0);
      check("R4", 2'(k + 1));
    end
    check("R2", 2'd3);

    // exhaustive: every state x every direction/value pair (R4, R5, R6)
    for (int s = 0; s < 4; s++) begin
      for (int d = 0; d < 2; d++) begin
        for (int v = 0; v < 32; v++) begin
          reach(s);
          applyOp(d[0], v, 1'b0);
          check(s == 3 ? "R6" : "R5", model(2'(s), d[0], v));
        end
      end
    end

    // R3: inputs wiggling without strobe leave every state alone
    for (int s = 0; s < 4; s++) begin
      reach(s);
      for (int v = 0; v < 32; v += 5) begin
        opDir = v[0]; opValue = VAL_W'(v);
        @(negedge clk);
      end
      opDir = stepDir(s % 3); opValue = VAL_W'(stepVal(s % 3));
      @(negedge clk);
      check("R3", 2'(s));
    end

    // R7: relock from every state, together with a matching strobe
    for (int s = 0; s < 4; s++) begin
      reach(s);
      applyOp(stepDir(s % 3), stepVal(s % 3), 1'b1);
      check("R7", 2'd0);
    end

    // R1: reset from the open state
    reach(3);
    doReset();
    check("R1", 2'd0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #1000000;
    miscompares++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule